// File: doc/BRIEF.md
# E1 Common-Channel Signaling Timeslot Router

This block sits behind an E1 receive framer whose frame alignment is already done. Received timeslot bytes arrive one per `rx_vld` strobe, with their timeslot number. The block keeps the bytes of the three signaling timeslots, 15, 16 and 31. During the next backplane frame it serialises them onto two outgoing TDM streams. The data stream always carries the three bytes at their own backplane positions. The control stream can carry a copy of any of them, in any of its 32 timeslots, when common-channel signaling is selected.

The backplane runs at one bit per `bp_ben` strobe, and `bp_fs` marks the first bit of a frame. At the low rate a frame is 32 slots of 8 bits. At the high rate four framers share the stream byte by byte, so a frame is 128 slots. This instance owns every fourth slot, starting at its framer index. It releases both output enables in the slots that belong to other framers. The configuration inputs and the captured signaling bytes change over only at a frame start, so no frame ever mixes two settings.

Top module: `e1_ccs_router`

## Requirements
- R1: When `cfg_ccs_en` is 0, every control-stream slot this instance owns outputs all ones with `cso_oe` high, whatever the enables and destination selects are.
- R2: In every frame, the data-stream positions of receive timeslots 15, 16 and 31 carry those bytes with `dso_oe` high, whatever the mode and enable bits are. All other positions drive `dso_oe` low and `dso` high.
- R3: `cfg_ts_en` bit 0 enables timeslot 15, bit 1 enables timeslot 16 and bit 2 enables timeslot 31. The bits act independently, and any combination may be set.
- R4: An enabled source with mode on appears in the control-stream timeslot named by its 5-bit select (`cfg_dst15`, `cfg_dst16`, `cfg_dst31`). Any value from 0 to 31 is valid.
- R5: Owned control-stream slots that no enabled source selects output all ones with `cso_oe` high.
- R6: Bit index i after `bp_fs` belongs to backplane slot i/8, bit i%8. At the low rate (`cfg_hi_rate`=0) a frame is 256 bits and slot c is timeslot c. At the high rate a frame is 1024 bits and slot c is timeslot c/4. Strobes past the frame length, or strobes after reset before the first `bp_fs`, drive both enables low.
- R7: At the high rate, a slot c with c%4 different from `cfg_framer_idx` drives both enables low and both data outputs high.
- R8: When several enabled sources select the same control slot, timeslot 15 wins over 16, and 16 wins over 31.
- R9: `rx_data[0]` holds line bit B1, the first bit received. It is sent first in its slot (bit position 0), and `rx_data[7]` is sent last.
- R10: The configuration inputs, and the bytes captured for timeslots 15, 16 and 31, are taken over only on a strobe with `bp_fs` high. A byte received in frame k is sent in the backplane frame that starts after it. A byte that arrives on the same cycle as that frame start waits one more frame.
- R11: During reset and after it, both enables are low and both data outputs are high until the first frame start. All stored signaling bytes reset to all ones.
- R12: The outputs for a strobe appear one clock after it and hold steady until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_vld | input | 1 | Receive byte strobe |
| rx_ts | input | 5 | Receive timeslot number of `rx_data` |
| rx_data | input | 8 | Received byte, bit 0 = first line bit |
| bp_fs | input | 1 | Backplane frame start, valid with `bp_ben` |
| bp_ben | input | 1 | Backplane bit strobe |
| cfg_ccs_en | input | 1 | Common-channel signaling mode |
| cfg_hi_rate | input | 1 | 0: 32-slot frame, 1: 4-way interleaved 128-slot frame |
| cfg_framer_idx | input | 2 | Interleave position of this instance |
| cfg_ts_en | input | 3 | Control-stream enables for timeslots 15/16/31 (bits 0/1/2) |
| cfg_dst15 | input | 5 | Control slot for timeslot 15 |
| cfg_dst16 | input | 5 | Control slot for timeslot 16 |
| cfg_dst31 | input | 5 | Control slot for timeslot 31 |
| dso | output | 1 | Data stream bit |
| dso_oe | output | 1 | Data stream drive enable |
| cso | output | 1 | Control stream bit |
| cso_oe | output | 1 | Control stream drive enable |

## Verification
The bench makes several sources collide in one control slot. A design with the wrong priority would send the wrong byte in that slot. It also drives strobes past the end of a frame and into the slots of other framers at the high rate; a design that miscounted the interleave would drive the shared stream in a foreign slot. It changes the configuration in the middle of a frame and lands received bytes exactly on the frame start cycle. A design that sampled too early would split a frame between two settings or send a byte one frame too soon. Gaps between strobes catch outputs that move without a strobe.

// File: rtl/e1ccs_pkg.sv
package e1ccs_pkg;
  localparam int TS_W     = 5;
  localparam int BYTE_W   = 8;
  localparam int NSRC     = 3;
  localparam int IL       = 4;
  localparam int FIDX_W   = $clog2(IL);
  localparam int SLOTS    = 1 << TS_W;
  localparam int BIT_W    = $clog2(BYTE_W);
  localparam int CH_W     = $clog2(IL * SLOTS);
  localparam int CNT_W    = CH_W + BIT_W + 1;
  localparam int LO_BITS  = SLOTS * BYTE_W;
  localparam int MAX_BITS = IL * SLOTS * BYTE_W;

  typedef struct packed {
    logic                      ccs_en;
    logic                      hi_rate;
    logic [FIDX_W-1:0]         fidx;
    logic [NSRC-1:0]           ts_en;
    logic [NSRC-1:0][TS_W-1:0] dst;
  } route_cfg_t;

  // receive timeslot feeding source index i
  function automatic logic [TS_W-1:0] src_ts(input int i);
    case (i)
      0:       return TS_W'(15);
      1:       return TS_W'(16);
      default: return TS_W'(31);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] frame_bits(input logic hi);
    return hi ? CNT_W'(MAX_BITS) : CNT_W'(LO_BITS);
  endfunction

  function automatic logic [TS_W-1:0] ch_to_ts(input logic [CH_W-1:0] ch, input logic hi);
    return hi ? ch[CH_W-1:FIDX_W] : ch[TS_W-1:0];
  endfunction

  function automatic logic ch_is_own(input logic [CH_W-1:0] ch, input logic hi,
                                     input logic [FIDX_W-1:0] fidx);
    return !hi || (ch[FIDX_W-1:0] == fidx);
  endfunction
endpackage

// File: rtl/e1ccs_capture.sv
module e1ccs_capture
  import e1ccs_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_vld,
  input  logic [TS_W-1:0]             rx_ts,
  input  logic [BYTE_W-1:0]           rx_data,
  input  logic                        swap,
  output logic [NSRC-1:0][BYTE_W-1:0] sig_eff
);
  logic [NSRC-1:0][BYTE_W-1:0] fill_q;
  logic [NSRC-1:0][BYTE_W-1:0] play_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '1;
      play_q <= '1;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        if (swap) play_q[i] <= fill_q[i];
        if (rx_vld && rx_ts == src_ts(i)) fill_q[i] <= rx_data;
      end
    end
  end

  // bytes seen by the frame that starts this cycle, or the current frame
  for (genvar g = 0; g < NSRC; g++) begin : g_eff
    assign sig_eff[g] = swap ? fill_q[g] : play_q[g];
  end
endmodule

// File: rtl/e1ccs_slot_timer.sv
module e1ccs_slot_timer
  import e1ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bp_ben,
  input  logic              frame_start,
  input  logic              hi_rate,
  input  logic [FIDX_W-1:0] fidx,
  output logic              slot_valid,
  output logic              slot_own,
  output logic [TS_W-1:0]   slot_ts,
  output logic [BIT_W-1:0]  bit_pos
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;
  logic [CH_W-1:0]  ch;

  assign idx = frame_start ? '0 : cnt_q;
  assign ch  = idx[CH_W+BIT_W-1:BIT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= CNT_W'(MAX_BITS);
    else if (bp_ben)
      cnt_q <= (idx >= CNT_W'(MAX_BITS)) ? CNT_W'(MAX_BITS) : idx + 1'b1;
  end

  assign slot_valid = idx < frame_bits(hi_rate);
  assign slot_own   = ch_is_own(ch, hi_rate, fidx);
  assign slot_ts    = ch_to_ts(ch, hi_rate);
  assign bit_pos    = idx[BIT_W-1:0];
endmodule

// File: rtl/e1ccs_router.sv
module e1ccs_router
  import e1ccs_pkg::*;
(
  input  logic                        slot_valid,
  input  logic                        slot_own,
  input  logic [TS_W-1:0]             slot_ts,
  input  logic [BIT_W-1:0]            bit_pos,
  input  route_cfg_t                  cfg_eff,
  input  logic [NSRC-1:0][BYTE_W-1:0] sig_eff,
  output logic                        dso_nxt,
  output logic                        dso_oe_nxt,
  output logic                        cso_nxt,
  output logic                        cso_oe_nxt
);
  logic [NSRC-1:0] data_hit;
  logic [NSRC-1:0] ctrl_hit;
  logic            drive;

  assign drive = slot_valid && slot_own;

  for (genvar g = 0; g < NSRC; g++) begin : g_hit
    assign data_hit[g] = slot_ts == src_ts(g);
    assign ctrl_hit[g] = cfg_eff.ccs_en && cfg_eff.ts_en[g] && (cfg_eff.dst[g] == slot_ts);
  end

  always_comb begin
    dso_nxt    = 1'b1;
    dso_oe_nxt = 1'b0;
    if (drive) begin
      for (int i = 0; i < NSRC; i++) begin
        if (data_hit[i]) begin
          dso_nxt    = sig_eff[i][bit_pos];
          dso_oe_nxt = 1'b1;
        end
      end
    end
  end

  // walk from lowest to highest priority so the lowest index lands last
  always_comb begin
    cso_nxt    = 1'b1;
    cso_oe_nxt = drive;
    if (drive) begin
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (ctrl_hit[i]) cso_nxt = sig_eff[i][bit_pos];
      end
    end
  end
endmodule

// File: rtl/e1_ccs_router.sv
module e1_ccs_router
  import e1ccs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_vld,
  input  logic [TS_W-1:0]   rx_ts,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              bp_fs,
  input  logic              bp_ben,
  input  logic              cfg_ccs_en,
  input  logic              cfg_hi_rate,
  input  logic [FIDX_W-1:0] cfg_framer_idx,
  input  logic [NSRC-1:0]   cfg_ts_en,
  input  logic [TS_W-1:0]   cfg_dst15,
  input  logic [TS_W-1:0]   cfg_dst16,
  input  logic [TS_W-1:0]   cfg_dst31,
  output logic              dso,
  output logic              dso_oe,
  output logic              cso,
  output logic              cso_oe
);
  route_cfg_t                  cfg_in;
  route_cfg_t                  cfg_q;
  route_cfg_t                  cfg_eff;
  logic                        frame_start;
  logic [NSRC-1:0][BYTE_W-1:0] sig_eff;
  logic                        slot_valid;
  logic                        slot_own;
  logic [TS_W-1:0]             slot_ts;
  logic [BIT_W-1:0]            bit_pos;
  logic                        dso_nxt;
  logic                        dso_oe_nxt;
  logic                        cso_nxt;
  logic                        cso_oe_nxt;

  assign frame_start = bp_fs && bp_ben;

  assign cfg_in.ccs_en  = cfg_ccs_en;
  assign cfg_in.hi_rate = cfg_hi_rate;
  assign cfg_in.fidx    = cfg_framer_idx;
  assign cfg_in.ts_en   = cfg_ts_en;
  assign cfg_in.dst     = {cfg_dst31, cfg_dst16, cfg_dst15};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cfg_q <= '0;
    else if (frame_start) cfg_q <= cfg_in;
  end

  assign cfg_eff = frame_start ? cfg_in : cfg_q;

  e1ccs_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_vld  (rx_vld),
    .rx_ts   (rx_ts),
    .rx_data (rx_data),
    .swap    (frame_start),
    .sig_eff (sig_eff)
  );

  e1ccs_slot_timer u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .bp_ben      (bp_ben),
    .frame_start (frame_start),
    .hi_rate     (cfg_eff.hi_rate),
    .fidx        (cfg_eff.fidx),
    .slot_valid  (slot_valid),
    .slot_own    (slot_own),
    .slot_ts     (slot_ts),
    .bit_pos     (bit_pos)
  );

  e1ccs_router u_rte (
    .slot_valid (slot_valid),
    .slot_own   (slot_own),
    .slot_ts    (slot_ts),
    .bit_pos    (bit_pos),
    .cfg_eff    (cfg_eff),
    .sig_eff    (sig_eff),
    .dso_nxt    (dso_nxt),
    .dso_oe_nxt (dso_oe_nxt),
    .cso_nxt    (cso_nxt),
    .cso_oe_nxt (cso_oe_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dso    <= 1'b1;
      dso_oe <= 1'b0;
      cso    <= 1'b1;
      cso_oe <= 1'b0;
    end else if (bp_ben) begin
      dso    <= dso_nxt;
      dso_oe <= dso_oe_nxt;
      cso    <= cso_nxt;
      cso_oe <= cso_oe_nxt;
    end
  end
endmodule

// File: rtl/e1_ccs_router_chk.sv
module e1_ccs_router_chk
  import e1ccs_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bp_ben,
  input logic                        frame_start,
  input route_cfg_t                  cfg_eff,
  input route_cfg_t                  cfg_q,
  input logic                        slot_valid,
  input logic                        slot_own,
  input logic [TS_W-1:0]             slot_ts,
  input logic [BIT_W-1:0]            bit_pos,
  input logic [NSRC-1:0][BYTE_W-1:0] sig_eff,
  input logic                        dso,
  input logic                        dso_oe,
  input logic                        cso,
  input logic                        cso_oe
);
  // R11
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (!dso_oe && !cso_oe));

  // R12
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bp_ben |=> ($stable(dso) && $stable(cso) && $stable(dso_oe) && $stable(cso_oe)));

  // R7
  foreign_slot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_ben && cfg_eff.hi_rate && !slot_own) |=> (!dso_oe && !cso_oe));

  // R6
  past_frame_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_ben && !slot_valid) |=> (!dso_oe && !cso_oe));

  // R1
  mode_off_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_ben && slot_valid && slot_own && !cfg_eff.ccs_en) |=> (cso && cso_oe));

  // R2
  data_ts16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_ben && slot_valid && slot_own && slot_ts == TS_W'(16))
      |=> (dso_oe && dso == $past(sig_eff[1][bit_pos])));

  // R8
  top_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_ben && slot_valid && slot_own && cfg_eff.ccs_en && cfg_eff.ts_en[0] &&
     cfg_eff.dst[0] == slot_ts) |=> (cso == $past(sig_eff[0][bit_pos])));

  // R10
  cfg_frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cfg_q));
endmodule

bind e1_ccs_router e1_ccs_router_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bp_ben      (bp_ben),
  .frame_start (frame_start),
  .cfg_eff     (cfg_eff),
  .cfg_q       (cfg_q),
  .slot_valid  (slot_valid),
  .slot_own    (slot_own),
  .slot_ts     (slot_ts),
  .bit_pos     (bit_pos),
  .sig_eff     (sig_eff),
  .dso         (dso),
  .dso_oe      (dso_oe),
  .cso         (cso),
  .cso_oe      (cso_oe)
);

// File: tb/e1_ccs_router_tb.sv
module e1_ccs_router_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_vld = 1'b0;
  logic [4:0] rx_ts = '0;
  logic [7:0] rx_data = '0;
  logic       bp_fs = 1'b0;
  logic       bp_ben = 1'b0;
  logic       cfg_ccs_en = 1'b0;
  logic       cfg_hi_rate = 1'b0;
  logic [1:0] cfg_framer_idx = '0;
  logic [2:0] cfg_ts_en = '0;
  logic [4:0] cfg_dst15 = '0, cfg_dst16 = '0, cfg_dst31 = '0;
  logic       dso, dso_oe, cso, cso_oe;

  int checks = 0;
  int fails = 0;
  int rx_phase = 0;
  int rx_next_ts = 0;
  bit done = 0;

  always #10 clk = ~clk;

  e1_ccs_router u_dut (
    .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_ts(rx_ts), .rx_data(rx_data),
    .bp_fs(bp_fs), .bp_ben(bp_ben), .cfg_ccs_en(cfg_ccs_en), .cfg_hi_rate(cfg_hi_rate),
    .cfg_framer_idx(cfg_framer_idx), .cfg_ts_en(cfg_ts_en), .cfg_dst15(cfg_dst15),
    .cfg_dst16(cfg_dst16), .cfg_dst31(cfg_dst31),
    .dso(dso), .dso_oe(dso_oe), .cso(cso), .cso_oe(cso_oe)
  );

  // ---------------- reference model ----------------
  int    m_fill[3], m_play[3];
  int    m_cnt;
  bit    m_ccs, m_hi;
  int    m_fi, m_en;
  int    m_dst[3];
  bit    e_dso = 1, e_doe = 0, e_cso = 1, e_coe = 0;
  string dtag = "R11", ctag = "R11";

  function automatic int srcts(int k);
    return (k == 0) ? 15 : (k == 1) ? 16 : 31;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_fill[k]) begin m_fill[k] = 255; m_play[k] = 255; m_dst[k] = 0; end
      m_cnt = 1024; m_ccs = 0; m_hi = 0; m_fi = 0; m_en = 0;
      e_dso = 1; e_doe = 0; e_cso = 1; e_coe = 0; dtag = "R11"; ctag = "R11";
    end else begin
      if (bp_ben) begin
        bit fs, eccs, ehi, own;
        int efi, een, idx, flen, ch, bp, t, src, hits, win;
        int ed[3], eb[3];
        string sfx;
        fs   = bp_fs;
        eccs = fs ? cfg_ccs_en : m_ccs;
        ehi  = fs ? cfg_hi_rate : m_hi;
        efi  = fs ? int'(cfg_framer_idx) : m_fi;
        een  = fs ? int'(cfg_ts_en) : m_en;
        ed[0] = fs ? int'(cfg_dst15) : m_dst[0];
        ed[1] = fs ? int'(cfg_dst16) : m_dst[1];
        ed[2] = fs ? int'(cfg_dst31) : m_dst[2];
        for (int k = 0; k < 3; k++) eb[k] = fs ? m_fill[k] : m_play[k];
        sfx = (!fs && (cfg_ccs_en != m_ccs || int'(cfg_ts_en) != m_en ||
               int'(cfg_dst15) != m_dst[0] || int'(cfg_dst16) != m_dst[1] ||
               int'(cfg_dst31) != m_dst[2])) ? " R10" : "";
        idx  = fs ? 0 : m_cnt;
        flen = ehi ? 1024 : 256;
        ch   = idx / 8;
        bp   = idx % 8;
        t    = ehi ? ch / 4 : ch;
        own  = ehi ? ((ch % 4) == efi) : 1'b1;
        if (idx >= flen) begin
          e_doe = 0; e_dso = 1; e_coe = 0; e_cso = 1;
          dtag = (m_cnt == 1024 && !fs) ? "R6 R11" : "R6"; ctag = dtag;
        end else if (!own) begin
          e_doe = 0; e_dso = 1; e_coe = 0; e_cso = 1; dtag = "R7"; ctag = "R7";
        end else begin
          src = (t == 15) ? 0 : (t == 16) ? 1 : (t == 31) ? 2 : -1;
          if (src >= 0) begin
            e_doe = 1; e_dso = eb[src][bp]; dtag = ehi ? "R2 R6 R9" : "R2 R9";
          end else begin
            e_doe = 0; e_dso = 1; dtag = "R2";
          end
          hits = 0; win = -1;
          for (int k = 0; k < 3; k++)
            if (eccs && een[k] && ed[k] == t) begin hits++; if (win < 0) win = k; end
          e_coe = 1;
          e_cso = (win < 0) ? 1'b1 : eb[win][bp];
          ctag  = !eccs ? "R1" : (hits > 1) ? "R8" : (hits == 1) ? "R3 R4" : "R5";
          ctag  = {ctag, sfx};
        end
        if (fs) begin
          for (int k = 0; k < 3; k++) m_play[k] = m_fill[k];
          m_ccs = cfg_ccs_en; m_hi = cfg_hi_rate; m_fi = int'(cfg_framer_idx);
          m_en = int'(cfg_ts_en);
          m_dst[0] = int'(cfg_dst15); m_dst[1] = int'(cfg_dst16); m_dst[2] = int'(cfg_dst31);
        end
        m_cnt = (idx >= 1024) ? 1024 : idx + 1;
      end else begin
        dtag = "R12"; ctag = "R12";
      end
      if (rx_vld)
        for (int k = 0; k < 3; k++) if (int'(rx_ts) == srcts(k)) m_fill[k] = int'(rx_data);
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(dso_oe == e_doe, {dtag, " dso_oe"}, dso_oe, e_doe);
    chk(dso == e_dso,    {dtag, " dso"},    dso,    e_dso);
    chk(cso_oe == e_coe, {ctag, " cso_oe"}, cso_oe, e_coe);
    chk(cso == e_cso,    {ctag, " cso"},    cso,    e_cso);
  endtask

  task automatic step(input bit fs, input bit ben);
    @(negedge clk);
    compare_all();
    bp_fs  = fs;
    bp_ben = ben;
    rx_phase++;
    if (rx_phase % 4 == 0) begin
      rx_vld     = 1'b1;
      rx_ts      = 5'(rx_next_ts);
      rx_data    = 8'($urandom);
      rx_next_ts = (rx_next_ts + 1) % 32;
    end else begin
      rx_vld = 1'b0;
    end
  endtask

  task automatic frames(input int n, input int len, input int gap);
    for (int f = 0; f < n; f++)
      for (int i = 0; i < len; i++) begin
        step(i == 0, 1'b1);
        for (int g = 0; g < gap; g++) step(1'b0, 1'b0);
      end
  endtask

  task automatic set_cfg(input bit ccs, input bit hi, input int fi, input int en,
                         input int d15, input int d16, input int d31);
    cfg_ccs_en = ccs; cfg_hi_rate = hi; cfg_framer_idx = 2'(fi); cfg_ts_en = 3'(en);
    cfg_dst15 = 5'(d15); cfg_dst16 = 5'(d16); cfg_dst31 = 5'(d31);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!dso_oe && !cso_oe, "R11 reset enables", {dso_oe, cso_oe}, 0);
    chk(dso && cso, "R11 reset data", {dso, cso}, 3);
    rst_n = 1'b1;
    // R11 strobes before the first frame start keep the outputs idle
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    chk(!dso_oe && !cso_oe, "R11 idle before frame", {dso_oe, cso_oe}, 0);

    // R3 R4 distinct destinations, plus strobes past the frame end (R6)
    set_cfg(1, 0, 0, 7, 3, 15, 31);
    frames(3, 258, 0);
    // R1 mode off
    set_cfg(0, 0, 0, 7, 3, 15, 31);
    frames(2, 256, 0);
    // R6 R7 high rate, this framer at position 2
    set_cfg(1, 1, 2, 5, 0, 5, 31);
    frames(2, 1024, 0);
    // R8 every source on slot 7
    set_cfg(1, 1, 0, 7, 7, 7, 7);
    frames(2, 1024, 0);
    // R12 gapped strobes, R10 mid-frame change
    set_cfg(1, 0, 0, 2, 9, 0, 9);
    frames(1, 256, 1);
    for (int i = 0; i < 256; i++) begin
      step(i == 0, 1'b1);
      step(1'b0, 1'b0);
      if (i == 100) set_cfg(1, 1, 3, 7, 20, 20, 2);
    end
    // high rate, last position, swapped slots
    set_cfg(1, 1, 3, 3, 16, 15, 4);
    frames(2, 1024, 0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule